// File: doc/BRIEF.md
# Accumulator Processor Core

A small multi-cycle processor built around a single 8-bit accumulator and an index register. Every instruction is two consecutive memory words: an opcode word and an operand word. The core brings both words in through a fixed chain of register transfers: the address register takes the program counter, the counter steps, the data register latches the memory word, and the word moves into its destination. It then executes one of eighteen operations. These are loads, a store, increment, compare with a jump-if-unequal, an unconditional jump, XOR/AND/OR with either an immediate value or a memory word, zero-filling shifts, character input and output, and halt.

The core talks to a synchronous single-port memory. The memory returns data one cycle after it sees an address. Character input uses a data port qualified by a valid level; the core waits in a dedicated state until that level is high. Character output is a one-cycle strobe with the accumulator on the output port. An undefined opcode stops the core and raises a fault flag. The index register is brought out so that its value can be observed.

Top module: `acc_cpu`

## Requirements
- R1: Opcode words sit at even program positions and each is followed by its operand word. The address order is: memory address takes PC, PC steps by one, the data register captures the returned word, and the word moves on to the instruction register. The operand word then follows the same order. After reset the memory address reads 0 in cycle 1, 1 in cycle 5, 2 in cycle 10 and 3 in cycle 14, where cycle 0 is the first clock after reset is released.
- R2: LDM (0x01) puts the operand into ACC. LDD (0x02) puts the memory word at the operand address into ACC. STO (0x03) writes ACC to the operand address.
- R3: INC (0x04) with operand bit 0 clear adds one to ACC, wrapping from 0xFF to 0x00. With operand bit 0 set it adds one to IX and leaves ACC unchanged. IX is visible on `idx_value`.
- R4: CMP (0x05) records whether ACC equals the memory word at the operand address. JPN (0x06) loads PC with its operand only when the recorded result is "unequal". JMP (0x07) always loads PC. The record keeps its value until the next CMP and reads "unequal" after reset.
- R5: XOR, AND and OR replace ACC with ACC combined with the operand in their immediate forms (0x0B, 0x0D, 0x0F), or with the memory word at the operand address in their address forms (0x0C, 0x0E, 0x10).
- R6: LSL (0x11) and LSR (0x12) shift ACC by the operand count, filling the vacated bits with zeros. A count of 8 or more gives 0x00.
- R7: IN (0x08) waits until `in_valid` is high and then loads `in_char` into ACC. No later instruction starts before that.
- R8: OUT (0x09) raises `out_valid` for exactly one cycle, with ACC on `out_char`.
- R9: END (0x0A) raises `halted`. `halted` then stays high until reset, and no memory write or output strobe occurs after it.
- R10: An opcode word with any of bits [7:5] set, or with a low five-bit code of 0x00 or 0x13 to 0x1F, halts the core with `fault` high.
- R11: Synchronous active-high reset clears PC, ACC, IX, the compare record, `halted` and `fault`, and drives memory address 0 with no write and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address (the address register) |
| mem_wdata | output | DATA_W | Write data (ACC) |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| in_char | input | DATA_W | Input character code |
| in_valid | input | 1 | Input character present |
| out_char | output | DATA_W | Output character code |
| out_valid | output | 1 | One-cycle output strobe |
| idx_value | output | DATA_W | Current index register |
| halted | output | 1 | Core stopped |
| fault | output | 1 | Stopped on an undefined opcode |

## Verification
The logic group is swept over a grid of accumulator and operand values for all six logic opcodes. Immediate and address forms are compared against the same arithmetic result, which separates an operand-select error from an operation error. Shifts run every count from 0 to 9 in both directions, so both the zero fill and the wide-count case are covered. Control flow is tried with the compare equal, with it unequal, and with no compare since reset. These cases separate a wrong polarity from a record that is lost or reset at the wrong moment. Fixed programs check the fetch addresses cycle by cycle, the input stall under a late `in_valid`, and the quiet bus after a halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_LDM  = 5'h01,
        OPC_LDD  = 5'h02,
        OPC_STO  = 5'h03,
        OPC_INC  = 5'h04,
        OPC_CMP  = 5'h05,
        OPC_JPN  = 5'h06,
        OPC_JMP  = 5'h07,
        OPC_IN   = 5'h08,
        OPC_OUT  = 5'h09,
        OPC_END  = 5'h0A,
        OPC_XORI = 5'h0B,
        OPC_XORA = 5'h0C,
        OPC_ANDI = 5'h0D,
        OPC_ANDA = 5'h0E,
        OPC_ORI  = 5'h0F,
        OPC_ORA  = 5'h10,
        OPC_LSL  = 5'h11,
        OPC_LSR  = 5'h12
    } opc_e;

    typedef enum logic [3:0] {
        ST_FMAR, ST_FINC, ST_FMDR, ST_FCIR,
        ST_OMAR, ST_OINC, ST_OMDR, ST_OOPR,
        ST_EXEC, ST_MWAIT, ST_MRD, ST_MEXEC,
        ST_STWR, ST_INWAIT, ST_HALT
    } state_e;

    typedef struct packed {
        logic mar_pc;
        logic mar_opr;
        logic pc_inc;
        logic pc_jump;
        logic mdr_load;
        logic cir_load;
        logic opr_load;
        logic acc_alu;
        logic acc_in;
        logic ix_inc;
        logic flag_load;
        logic alu_mem;
        logic mem_we;
        logic out_pulse;
    } ctrl_t;

    function automatic logic opc_reads_mem(opc_e op);
        return (op == OPC_LDD) || (op == OPC_CMP) || (op == OPC_XORA) ||
               (op == OPC_ANDA) || (op == OPC_ORA);
    endfunction

    function automatic logic opc_acc_imm(opc_e op);
        return (op == OPC_LDM) || (op == OPC_XORI) || (op == OPC_ANDI) ||
               (op == OPC_ORI) || (op == OPC_LSL) || (op == OPC_LSR);
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  opc_e              op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opr,
    input  logic [DATA_W-1:0] mdr,
    input  logic              use_mem,
    output logic [DATA_W-1:0] result,
    output logic              equal
);
    logic [DATA_W-1:0] b_val;

    always_comb begin
        b_val = use_mem ? mdr : opr;
        case (op)
            OPC_LDM, OPC_LDD:   result = b_val;
            OPC_INC:            result = acc + DATA_W'(1);
            OPC_XORI, OPC_XORA: result = acc ^ b_val;
            OPC_ANDI, OPC_ANDA: result = acc & b_val;
            OPC_ORI,  OPC_ORA:  result = acc | b_val;
            OPC_LSL:            result = acc << b_val;
            OPC_LSR:            result = acc >> b_val;
            default:            result = acc;
        endcase
    end

    assign equal = (acc == mdr);

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_word,
    input  logic              sel_ix,
    input  logic              cmp_equal,
    input  logic              in_valid,
    output ctrl_t             ctl,
    output logic              halted,
    output logic              fault
);
    localparam int unsigned HI_W = DATA_W - OPC_W;

    state_e state, nxt;
    logic   bad_op;
    opc_e   op;
    logic   hi_clear;

    assign op       = opc_e'(op_word[OPC_W-1:0]);
    assign hi_clear = (op_word[DATA_W-1:OPC_W] == HI_W'(0));

    always_comb begin
        ctl    = '0;
        nxt    = state;
        bad_op = 1'b0;
        case (state)
            ST_FMAR:  begin ctl.mar_pc   = 1'b1; nxt = ST_FINC; end
            ST_FINC:  begin ctl.pc_inc   = 1'b1; nxt = ST_FMDR; end
            ST_FMDR:  begin ctl.mdr_load = 1'b1; nxt = ST_FCIR; end
            ST_FCIR:  begin ctl.cir_load = 1'b1; nxt = ST_OMAR; end
            ST_OMAR:  begin ctl.mar_pc   = 1'b1; nxt = ST_OINC; end
            ST_OINC:  begin ctl.pc_inc   = 1'b1; nxt = ST_OMDR; end
            ST_OMDR:  begin ctl.mdr_load = 1'b1; nxt = ST_OOPR; end
            ST_OOPR:  begin ctl.opr_load = 1'b1; nxt = ST_EXEC; end
            ST_EXEC: begin
                nxt = ST_FMAR;
                if (!hi_clear) begin
                    bad_op = 1'b1;
                    nxt    = ST_HALT;
                end else begin
                    case (op)
                        OPC_LDM, OPC_XORI, OPC_ANDI, OPC_ORI, OPC_LSL, OPC_LSR:
                            ctl.acc_alu = 1'b1;
                        OPC_LDD, OPC_CMP, OPC_XORA, OPC_ANDA, OPC_ORA: begin
                            ctl.mar_opr = 1'b1;
                            nxt         = ST_MWAIT;
                        end
                        OPC_STO: begin
                            ctl.mar_opr = 1'b1;
                            nxt         = ST_STWR;
                        end
                        OPC_INC: begin
                            ctl.ix_inc  = sel_ix;
                            ctl.acc_alu = !sel_ix;
                        end
                        OPC_JMP: ctl.pc_jump   = 1'b1;
                        OPC_JPN: ctl.pc_jump   = !cmp_equal;
                        OPC_IN:  nxt           = ST_INWAIT;
                        OPC_OUT: ctl.out_pulse = 1'b1;
                        OPC_END: nxt           = ST_HALT;
                        default: begin
                            bad_op = 1'b1;
                            nxt    = ST_HALT;
                        end
                    endcase
                end
            end
            ST_MWAIT: nxt = ST_MRD;
            ST_MRD:   begin ctl.mdr_load = 1'b1; nxt = ST_MEXEC; end
            ST_MEXEC: begin
                ctl.alu_mem   = 1'b1;
                ctl.flag_load = (op == OPC_CMP);
                ctl.acc_alu   = (op != OPC_CMP);
                nxt           = ST_FMAR;
            end
            ST_STWR:  begin ctl.mem_we = 1'b1; nxt = ST_FMAR; end
            ST_INWAIT: begin
                if (in_valid) begin
                    ctl.acc_in = 1'b1;
                    nxt        = ST_FMAR;
                end
            end
            default:  nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FMAR;
            fault <= 1'b0;
        end else begin
            state <= nxt;
            if (bad_op) fault <= 1'b1;
        end
    end

    assign halted = (state == ST_HALT);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9
    AST_FAULT_MEANS_HALT: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted); // R10
    AST_IN_HOLDS_UNTIL_VALID: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INWAIT && !in_valid) |-> !ctl.acc_in); // R7

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] in_char,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_equal,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] ix,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] cir,
    output logic [DATA_W-1:0] opr,
    output logic              eq_flag
);
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] opr_addr;

    assign opr_addr = opr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            mar     <= '0;
            mdr     <= '0;
            cir     <= '0;
            opr     <= '0;
            acc     <= '0;
            ix      <= '0;
            eq_flag <= 1'b0;
        end else begin
            if (ctl.mar_pc)         mar <= pc;
            else if (ctl.mar_opr)   mar <= opr_addr;
            if (ctl.pc_inc)         pc  <= pc + ADDR_W'(1);
            else if (ctl.pc_jump)   pc  <= opr_addr;
            if (ctl.mdr_load)       mdr <= mem_rdata;
            if (ctl.cir_load)       cir <= mdr;
            if (ctl.opr_load)       opr <= mdr;
            if (ctl.acc_in)         acc <= in_char;
            else if (ctl.acc_alu)   acc <= alu_result;
            if (ctl.ix_inc)         ix  <= ix + DATA_W'(1);
            if (ctl.flag_load)      eq_flag <= alu_equal;
        end
    end

    AST_OPCODE_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        ctl.cir_load |-> (pc == mar + ADDR_W'(1))); // R1
    AST_OPERAND_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        ctl.opr_load |-> (pc == mar + ADDR_W'(1))); // R1
    AST_IN_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_in |=> (acc == $past(in_char))); // R7
    AST_IX_ONLY_ON_INC: assert property (@(posedge clk) disable iff (rst)
        !ctl.ix_inc |=> $stable(ix)); // R3

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] in_char,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_char,
    output logic              out_valid,
    output logic [DATA_W-1:0] idx_value,
    output logic              halted,
    output logic              fault
);
    ctrl_t             ctl;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] acc, ix, mdr, cir, opr;
    logic [DATA_W-1:0] alu_result;
    logic              alu_equal, eq_flag;

    acc_cpu_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst(rst), .op_word(cir), .sel_ix(opr[0]),
        .cmp_equal(eq_flag), .in_valid(in_valid), .ctl(ctl),
        .halted(halted), .fault(fault)
    );

    acc_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
        .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
        .in_char(in_char), .alu_result(alu_result), .alu_equal(alu_equal),
        .mar(mar), .acc(acc), .ix(ix), .mdr(mdr), .cir(cir), .opr(opr),
        .eq_flag(eq_flag)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
        .op(opc_e'(cir[OPC_W-1:0])), .acc(acc), .opr(opr), .mdr(mdr),
        .use_mem(ctl.alu_mem), .result(alu_result), .equal(alu_equal)
    );

    assign mem_addr  = mar;
    assign mem_wdata = acc;
    assign mem_we    = ctl.mem_we;
    assign out_char  = acc;
    assign out_valid = ctl.out_pulse;
    assign idx_value = ix;

    AST_OUT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R8
    AST_QUIET_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !out_valid)); // R9

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
    localparam int DW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, in_char, out_char, idx_value;
    logic          mem_we, in_valid, out_valid, halted, fault;

    logic [7:0] mem [0:255];
    logic [7:0] out_log [0:15];
    int         out_t [0:15];
    int         out_n, wr_after_halt, tcnt, in_start, cyc;
    logic [7:0] trace [0:31];
    int         n_cmp, n_bad;

    always #4 clk = ~clk;

    acc_cpu #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .in_char(in_char),
        .in_valid(in_valid), .out_char(out_char), .out_valid(out_valid),
        .idx_value(idx_value), .halted(halted), .fault(fault)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst) begin
            out_n = 0; wr_after_halt = 0; tcnt = 0;
        end else begin
            if (tcnt < 32) trace[tcnt] = mem_addr;
            if (out_valid) begin
                if (out_n < 16) begin out_log[out_n] = out_char; out_t[out_n] = tcnt; end
                out_n++;
            end
            if (halted && mem_we) wr_after_halt++;
            tcnt++;
        end
    end

    always @(negedge clk) begin
        in_valid = !rst && (tcnt >= in_start);
        in_char  = 8'h41;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst = 1'b1;
        in_start = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input int a, input logic [7:0] op, input logic [7:0] arg);
        mem[a]     = op;
        mem[a + 1] = arg;
    endtask

    task automatic run(input string req);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
        check({req, " program halts"}, int'(halted), 1);
    endtask

    function automatic logic [7:0] exp_logic(input int kind, input logic [7:0] a, input logic [7:0] b);
        if (kind == 0) return a ^ b;
        if (kind == 1) return a & b;
        return a | b;
    endfunction

    task automatic logic_case(input logic [7:0] code, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] exp;
        begin_prog();
        put(0, 8'h01, a);
        if (code[0]) put(2, code, b);          // immediate forms are odd codes
        else begin put(2, code, 8'h90); mem[8'h90] = b; end
        put(4, 8'h09, 8'h00);
        put(6, 8'h0A, 8'h00);
        run("R5");
        exp = exp_logic((int'(code) - 8'h0B) / 2, a, b);
        check("R5 logic result", int'(out_log[0]), int'(exp));
    endtask

    initial begin
        n_cmp = 0; n_bad = 0; cyc = 0; in_start = 0;

        // R11: reset state after a program that left IX and the fault set
        begin_prog();
        put(0, 8'h04, 8'h01);
        put(2, 8'h1F, 8'h00);
        run("R11");
        begin_prog();
        @(negedge clk); @(negedge clk);
        check("R11 halted", int'(halted), 0);
        check("R11 fault", int'(fault), 0);
        check("R11 idx", int'(idx_value), 0);
        check("R11 addr", int'(mem_addr), 0);
        check("R11 we/strobe", int'({mem_we, out_valid}), 0);

        // R1: fetch addresses, R2: load/store
        put(0, 8'h01, 8'h3C);
        put(2, 8'h03, 8'h80);
        put(4, 8'h01, 8'h00);
        put(6, 8'h02, 8'h80);
        put(8, 8'h09, 8'h00);
        put(10, 8'h0A, 8'h00);
        run("R2");
        check("R1 addr cycle1", int'(trace[1]), 0);
        check("R1 addr cycle5", int'(trace[5]), 1);
        check("R1 addr cycle10", int'(trace[10]), 2);
        check("R1 addr cycle14", int'(trace[14]), 3);
        check("R2 stored word", int'(mem[8'h80]), 8'h3C);
        check("R2 reloaded acc", int'(out_log[0]), 8'h3C);
        check("R10 no fault on valid code", int'(fault), 0);

        // R3: increment ACC with wrap, IX without touching ACC
        begin_prog();
        put(0, 8'h01, 8'hFF);
        put(2, 8'h04, 8'h00);
        put(4, 8'h09, 8'h00);
        put(6, 8'h04, 8'h01);
        put(8, 8'h04, 8'h01);
        put(10, 8'h09, 8'h00);
        put(12, 8'h0A, 8'h00);
        run("R3");
        check("R3 acc wrap", int'(out_log[0]), 0);
        check("R3 acc kept by IX inc", int'(out_log[1]), 0);
        check("R3 idx", int'(idx_value), 2);

        // R4: compare equal, unequal, none, and JMP
        for (int v = 0; v < 4; v++) begin
            begin_prog();
            if (v < 2) begin
                put(0, 8'h01, 8'h05);
                put(2, 8'h05, 8'h90);
                put(4, 8'h01, 8'h09);               // flag must survive this load
                mem[8'h90] = (v == 0) ? 8'h05 : 8'h06;
                put(6, 8'h06, 8'h40);
            end else begin
                put(0, 8'h01, 8'h09);
                put(2, 8'h01, 8'h09);
                put(4, 8'h01, 8'h09);
                put(6, (v == 2) ? 8'h06 : 8'h07, 8'h40);
            end
            put(8, 8'h09, 8'h00);
            put(10, 8'h0A, 8'h00);
            put(8'h40, 8'h01, 8'hEE);
            put(8'h42, 8'h09, 8'h00);
            put(8'h44, 8'h0A, 8'h00);
            run("R4");
            check("R4 branch outcome", int'(out_log[0]), (v == 0) ? 8'h09 : 8'hEE);
            check("R4 single output", out_n, 1);
        end

        // R5: logic sweep and fixed examples
        for (int k = 0; k < 6; k++)
            for (int a = 0; a < 256; a += 15)
                for (int b = 0; b < 256; b += 17)
                    logic_case(8'(8'h0B + k), 8'(a), 8'(b));
        logic_case(8'h10, 8'hFF, 8'hF0);
        logic_case(8'h0B, 8'h00, 8'd15);
        logic_case(8'h0E, 8'h55, 8'h00);

        // R6: shifts with zero fill
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < 256; a += 17)
                for (int n = 0; n < 10; n++) begin
                    logic [7:0] av, ex;
                    av = 8'(a) ^ 8'hA5;
                    ex = (d == 0) ? (av << n) : (av >> n);
                    begin_prog();
                    put(0, 8'h01, av);
                    put(2, (d == 0) ? 8'h11 : 8'h12, 8'(n));
                    put(4, 8'h09, 8'h00);
                    put(6, 8'h0A, 8'h00);
                    run("R6");
                    check("R6 shift result", int'(out_log[0]), int'(ex));
                end
        begin_prog();
        put(0, 8'h01, 8'hAA); put(2, 8'h12, 8'h02); put(4, 8'h09, 8'h00); put(6, 8'h0A, 8'h00);
        run("R6");
        check("R6 example right by 2", int'(out_log[0]), 8'h2A);

        // R7, R8: input stall then output strobe
        begin_prog();
        in_start = 40;
        put(0, 8'h08, 8'h00);
        put(2, 8'h09, 8'h00);
        put(4, 8'h0A, 8'h00);
        run("R7");
        check("R7 input char", int'(out_log[0]), 8'h41);
        check("R7 waited for valid", int'(out_t[0] > 40), 1);
        check("R8 strobe count", out_n, 1);

        // R9: halt is final
        begin_prog();
        put(0, 8'h01, 8'h01);
        put(2, 8'h0A, 8'h00);
        put(4, 8'h03, 8'h70);
        put(6, 8'h09, 8'h00);
        run("R9");
        repeat (20) @(negedge clk);
        check("R9 still halted", int'(halted), 1);
        check("R9 no write", int'(mem[8'h70]) + wr_after_halt, 0);
        check("R9 no output", out_n, 0);

        // R10: undefined opcodes
        for (int u = 0; u < 3; u++) begin
            begin_prog();
            put(0, (u == 0) ? 8'h00 : (u == 1) ? 8'h1F : 8'h21, 8'h00);
            put(2, 8'h09, 8'h00);
            run("R10");
            check("R10 fault", int'(fault), 1);
            check("R10 no output", out_n, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule